// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used virtual-to-physical page mappings next to the load/store path. A request carries a 48-bit virtual address, a user/kernel flag and a read/write flag. The request is answered in the same cycle with a hit flag, the 32-bit physical address and a protection-fault flag. The page size is 4 KB. The virtual page number selects one of four sets through its low bits, and its remaining bits are compared as a tag against the four ways of that set. Each stored entry keeps the physical page number, a valid flag and three permission flags: supervisor-only, readable and writable. Protection is therefore resolved on a hit with no table walk.

A separate fill port writes an entry produced by the page walker. The fill overwrites a way that already holds the same page if there is one. Otherwise it uses the lowest-numbered empty way. If the set is full, it replaces the way named by that set's round-robin pointer. A flush input drops every mapping in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every lookup misses; a missing or absent lookup drives hit 0, fault 0 and physical address 0.
- R2: A lookup of a page that has been filled hits, and the physical address is the stored 20-bit page number followed by virtual address bits 11:0 unchanged.
- R3: The set index is virtual address bits 13:12 and the tag is bits 47:14; for a fill, the index is fill page number bits 1:0 and the tag is bits 35:2. A lookup hits only when both index and tag match a valid entry.
- R4: A hitting user-mode lookup (user flag 1) of an entry whose supervisor flag is 1 reports a fault; a kernel-mode lookup of the same entry does not.
- R5: A hitting write (write flag 1) to an entry whose writable flag is 0 faults, and so does a hitting read (write flag 0) of an entry whose readable flag is 0; the other direction of access to such an entry does not fault.
- R6: Hit and fault are 0 whenever the request-valid input is 0, and fault is 1 only together with hit.
- R7: A fill into a set that has an empty way takes the lowest-numbered empty way, so four distinct pages fit in one set without loss.
- R8: A fill into a full set with no matching tag replaces the way named by that set's pointer (0 after reset), and the pointer then advances by one modulo 4. Each set has its own pointer.
- R9: A fill whose page is already present overwrites that way in place, evicts nothing and leaves the pointer unchanged.
- R10: A flush clears every entry at the next clock edge. A fill in the same cycle as a flush is dropped.
- R11: A lookup in the same cycle as a fill to the same page sees the contents from before the fill; the new contents are visible from the next cycle.
- R12: The lookup is combinational: hit, fault and address are valid in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request present |
| lk_vaddr_i | input | 48 | Virtual address of the lookup |
| lk_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_write_i | input | 1 | 1 = write access, 0 = read access |
| lk_hit_o | output | 1 | Lookup found a valid mapping |
| lk_paddr_o | output | 32 | Translated physical address (0 on miss) |
| lk_fault_o | output | 1 | Hit with a permission violation |
| fill_valid_i | input | 1 | Write one entry this cycle |
| fill_vpn_i | input | 36 | Virtual page number of the filled entry |
| fill_ppn_i | input | 20 | Physical page number of the filled entry |
| fill_sup_i | input | 1 | Entry is supervisor-only |
| fill_rd_i | input | 1 | Entry is readable |
| fill_wr_i | input | 1 | Entry is writable |
| flush_i | input | 1 | Invalidate all entries |

## Verification
Lookup outputs are due in the same cycle as the request, with no register in between. Fills and flushes change state at the next rising edge, so their effect appears in the lookup of the following cycle. The bench drives every input 1 ns after a rising edge and samples the outputs at the falling edge of that same cycle. Each cycle, it compares them against a behavioural model. The model applies fills and flushes only at the rising edge, so a lookup that shares a cycle with a fill is judged against the contents from before that fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic sup;
    logic rd;
    logic wr;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 34,
  parameter int PPN_W = 20
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0][PPN_W-1:0]  ppns_i,
  input  tlb_pkg::tlb_perm_t [WAYS-1:0] perms_i,
  output logic                        hit_o,
  output logic [PPN_W-1:0]            ppn_o,
  output tlb_pkg::tlb_perm_t          perm_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec;

  // at most one way hits; OR-mux selects it
  always_comb begin
    ppn_o  = '0;
    perm_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        ppn_o  = ppn_o | ppns_i[w];
        perm_o = tlb_pkg::tlb_perm_t'(perm_o | perms_i[w]);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 34,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic [WAY_W-1:0]           rr_i,
  output logic [WAY_W-1:0]           way_o,
  output logic                       rr_adv_o
);
  logic             match_found, free_found;
  logic [WAY_W-1:0] match_way, free_way;

  // descending scan leaves the lowest index
  always_comb begin
    match_found = 1'b0;
    free_found  = 1'b0;
    match_way   = '0;
    free_way    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_i[w] && tags_i[w] == tag_i) begin
        match_found = 1'b1;
        match_way   = WAY_W'(w);
      end
      if (!vld_i[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (match_found) begin
      way_o    = match_way;
      rr_adv_o = 1'b0;
    end else if (free_found) begin
      way_o    = free_way;
      rr_adv_o = 1'b0;
    end else begin
      way_o    = rr_i;
      rr_adv_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_user_i,
  input  logic             lk_write_i,
  output logic             lk_hit_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic             lk_fault_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_sup_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             flush_i
);
  import tlb_pkg::*;

  logic      [SETS-1:0][WAYS-1:0]             vld_q;
  logic      [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic      [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;
  tlb_perm_t [SETS-1:0][WAYS-1:0]             perm_q;
  logic      [SETS-1:0][WAY_W-1:0]            rr_q;

  // lookup path
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_match;
  logic [PPN_W-1:0] lk_ppn;
  tlb_perm_t        lk_perm;

  assign lk_idx = lk_vaddr_i[PAGE_W +: IDX_W];
  assign lk_tag = lk_vaddr_i[VA_W-1 -: TAG_W];

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_lk_match (
    .vld_i  (vld_q[lk_idx]),
    .tag_i  (lk_tag),
    .tags_i (tag_q[lk_idx]),
    .ppns_i (ppn_q[lk_idx]),
    .perms_i(perm_q[lk_idx]),
    .hit_o  (lk_match),
    .ppn_o  (lk_ppn),
    .perm_o (lk_perm)
  );

  logic deny;
  assign deny = (lk_user_i && lk_perm.sup) ||
                (lk_write_i ? !lk_perm.wr : !lk_perm.rd);

  assign lk_hit_o   = lk_valid_i && lk_match;
  assign lk_fault_o = lk_hit_o && deny;
  assign lk_paddr_o = lk_hit_o ? {lk_ppn, lk_vaddr_i[PAGE_W-1:0]} : '0;

  // fill path
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  logic [WAY_W-1:0] f_way;
  logic             f_adv;
  logic             f_we;

  assign f_idx = fill_vpn_i[IDX_W-1:0];
  assign f_tag = fill_vpn_i[VPN_W-1:IDX_W];
  assign f_we  = fill_valid_i && !flush_i;

  tlb_victim #(.WAYS(WAYS), .TAG_W(TAG_W)) u_victim (
    .vld_i   (vld_q[f_idx]),
    .tags_i  (tag_q[f_idx]),
    .tag_i   (f_tag),
    .rr_i    (rr_q[f_idx]),
    .way_o   (f_way),
    .rr_adv_o(f_adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_valid_i) begin
      vld_q[f_idx][f_way] <= 1'b1;
      if (f_adv) rr_q[f_idx] <= f_way + WAY_W'(1);
    end
  end

  // payload needs no reset: guarded by vld_q
  always_ff @(posedge clk_i) begin
    if (f_we) begin
      tag_q[f_idx][f_way]  <= f_tag;
      ppn_q[f_idx][f_way]  <= fill_ppn_i;
      perm_q[f_idx][f_way] <= '{sup: fill_sup_i, rd: fill_rd_i, wr: fill_wr_i};
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_valid_i,
  input logic [VA_W-1:0]        lk_vaddr_i,
  input logic                   lk_hit_o,
  input logic [PA_W-1:0]        lk_paddr_o,
  input logic                   lk_fault_o,
  input logic                   fill_valid_i,
  input logic [VA_W-PAGE_W-1:0] fill_vpn_i,
  input logic                   flush_i
);
  // R6
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_valid_i);

  // R6
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);

  // R1
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && !lk_fault_o));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[PAGE_W-1:0] == lk_vaddr_i[PAGE_W-1:0]));

  // R10
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);

  // R2
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=>
      (!lk_valid_i || lk_vaddr_i[VA_W-1:PAGE_W] != $past(fill_vpn_i) || lk_hit_o));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .lk_vaddr_i  (lk_vaddr_i),
  .lk_hit_o    (lk_hit_o),
  .lk_paddr_o  (lk_paddr_o),
  .lk_fault_o  (lk_fault_o),
  .fill_valid_i(fill_valid_i),
  .fill_vpn_i  (fill_vpn_i),
  .flush_i     (flush_i)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [47:0] lk_vaddr_i = '0;
  logic        lk_user_i = 1'b0;
  logic        lk_write_i = 1'b0;
  logic        lk_hit_o;
  logic [31:0] lk_paddr_o;
  logic        lk_fault_o;
  logic        fill_valid_i = 1'b0;
  logic [35:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic        fill_sup_i = 1'b0;
  logic        fill_rd_i = 1'b0;
  logic        fill_wr_i = 1'b0;
  logic        flush_i = 1'b0;

  always #2 clk_i = ~clk_i;

  tlb_xlate u_dut (.*);

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  bit          m_vld [4][4];
  logic [33:0] m_tag [4][4];
  logic [19:0] m_ppn [4][4];
  bit          m_sup [4][4];
  bit          m_rd  [4][4];
  bit          m_wr  [4][4];
  int          m_ptr [4];

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mkva(input logic [33:0] t, input logic [1:0] i,
                                       input logic [11:0] o);
    return {t, i, o};
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (m_vld[s, w]) m_vld[s][w] = 1'b0;
      foreach (m_ptr[s]) m_ptr[s] = 0;
    end else if (flush_i) begin
      foreach (m_vld[s, w]) m_vld[s][w] = 1'b0;
    end else if (fill_valid_i) begin
      int s;
      int pick;
      s = int'(fill_vpn_i[1:0]);
      pick = -1;
      for (int w = 0; w < 4; w++)
        if (pick < 0 && m_vld[s][w] && m_tag[s][w] == fill_vpn_i[35:2]) pick = w;
      for (int w = 0; w < 4; w++)
        if (pick < 0 && !m_vld[s][w]) pick = w;
      if (pick < 0) begin
        pick = m_ptr[s];
        m_ptr[s] = (m_ptr[s] + 1) % 4;
      end
      m_vld[s][pick] = 1'b1;
      m_tag[s][pick] = fill_vpn_i[35:2];
      m_ppn[s][pick] = fill_ppn_i;
      m_sup[s][pick] = fill_sup_i;
      m_rd[s][pick]  = fill_rd_i;
      m_wr[s][pick]  = fill_wr_i;
    end
  end

  // per-cycle comparison against the model (R12: same-cycle result)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit          eh, ef;
      logic [31:0] ep;
      int          s;
      eh = 1'b0; ef = 1'b0; ep = '0;
      s = int'(lk_vaddr_i[13:12]);
      if (lk_valid_i)
        for (int w = 0; w < 4; w++)
          if (m_vld[s][w] && m_tag[s][w] == lk_vaddr_i[47:14]) begin
            eh = 1'b1;
            ep = {m_ppn[s][w], lk_vaddr_i[11:0]};
            ef = (lk_user_i && m_sup[s][w]) || (lk_write_i ? !m_wr[s][w] : !m_rd[s][w]);
          end
      chk(lk_hit_o === eh, req, "model hit", 64'(lk_hit_o), 64'(eh));
      chk(lk_fault_o === ef, req, "model fault", 64'(lk_fault_o), 64'(ef));
      chk(lk_paddr_o === ep, req, "model paddr", 64'(lk_paddr_o), 64'(ep));
    end
  end

  task automatic drive(input bit lv, input logic [47:0] va, input bit usr, input bit wr,
                       input bit fv, input logic [35:0] vpn, input logic [19:0] ppn,
                       input bit s, input bit r, input bit w, input bit fl);
    @(posedge clk_i);
    #1;
    lk_valid_i = lv; lk_vaddr_i = va; lk_user_i = usr; lk_write_i = wr;
    fill_valid_i = fv; fill_vpn_i = vpn; fill_ppn_i = ppn;
    fill_sup_i = s; fill_rd_i = r; fill_wr_i = w; flush_i = fl;
  endtask

  task automatic fill(input logic [33:0] t, input logic [1:0] i, input logic [19:0] ppn,
                      input bit s, input bit r, input bit w);
    drive(1'b0, '0, 1'b0, 1'b0, 1'b1, {t, i}, ppn, s, r, w, 1'b0);
  endtask

  task automatic look(input string r, input bit lv, input logic [47:0] va, input bit usr,
                      input bit wr, input bit eh, input bit ef, input logic [31:0] ep);
    req = r;
    drive(lv, va, usr, wr, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk(lk_hit_o === eh, r, "hit", 64'(lk_hit_o), 64'(eh));
    chk(lk_fault_o === ef, r, "fault", 64'(lk_fault_o), 64'(ef));
    chk(lk_paddr_o === ep, r, "paddr", 64'(lk_paddr_o), 64'(ep));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    look("R1", 1, mkva(1, 1, 0), 0, 0, 0, 0, 32'h0);
    look("R1", 1, mkva(0, 0, 12'hfff), 1, 1, 0, 0, 32'h0);

    // R2 / R12 basic translation
    fill(1, 1, 20'habcde, 0, 1, 1);
    look("R2", 1, mkva(1, 1, 12'h123), 0, 0, 1, 0, 32'habcde123);
    look("R12", 1, mkva(1, 1, 12'hfed), 1, 1, 1, 0, 32'habcdefed);

    // R3 index/tag split
    look("R3", 1, mkva(1, 2, 0), 0, 0, 0, 0, 32'h0);
    look("R3", 1, mkva(2, 1, 0), 0, 0, 0, 0, 32'h0);

    // R4 supervisor page
    fill(2, 1, 20'h11111, 1, 1, 1);
    look("R4", 1, mkva(2, 1, 12'h010), 1, 0, 1, 1, 32'h11111010);
    look("R4", 1, mkva(2, 1, 12'h010), 0, 0, 1, 0, 32'h11111010);
    look("R4", 1, mkva(2, 1, 12'h010), 0, 1, 1, 0, 32'h11111010);

    // R5 read-only and write-only pages
    fill(3, 1, 20'h22222, 0, 1, 0);
    look("R5", 1, mkva(3, 1, 0), 1, 1, 1, 1, 32'h22222000);
    look("R5", 1, mkva(3, 1, 0), 1, 0, 1, 0, 32'h22222000);
    fill(4, 1, 20'h33333, 0, 0, 1);
    look("R5", 1, mkva(4, 1, 4), 0, 0, 1, 1, 32'h33333004);
    look("R5", 1, mkva(4, 1, 4), 0, 1, 1, 0, 32'h33333004);

    // R6 no request
    look("R6", 0, mkva(3, 1, 0), 1, 1, 0, 0, 32'h0);

    // R7 four pages into set 2
    for (int t = 10; t < 14; t++) fill(34'(t), 2, 20'(32'h100 + t), 0, 1, 1);
    for (int t = 10; t < 14; t++)
      look("R7", 1, mkva(34'(t), 2, 0), 0, 0, 1, 0, {20'(32'h100 + t), 12'h0});

    // R8 round-robin replacement
    fill(14, 2, 20'h114, 0, 1, 1);
    look("R8", 1, mkva(10, 2, 0), 0, 0, 0, 0, 32'h0);
    look("R8", 1, mkva(14, 2, 0), 0, 0, 1, 0, 32'h00114000);
    look("R8", 1, mkva(11, 2, 0), 0, 0, 1, 0, 32'h0010b000);
    fill(15, 2, 20'h115, 0, 1, 1);
    look("R8", 1, mkva(11, 2, 0), 0, 0, 0, 0, 32'h0);
    for (int t = 20; t < 25; t++) fill(34'(t), 3, 20'(t), 0, 1, 1);
    look("R8", 1, mkva(20, 3, 0), 0, 0, 0, 0, 32'h0);
    look("R8", 1, mkva(21, 3, 0), 0, 0, 1, 0, 32'h00015000);

    // R9 refill in place keeps pointer
    fill(12, 2, 20'h07777, 0, 1, 1);
    look("R9", 1, mkva(12, 2, 8), 0, 0, 1, 0, 32'h07777008);
    look("R9", 1, mkva(13, 2, 0), 0, 0, 1, 0, 32'h0010d000);
    fill(16, 2, 20'h116, 0, 1, 1);
    look("R9", 1, mkva(12, 2, 0), 0, 0, 0, 0, 32'h0);
    look("R9", 1, mkva(13, 2, 0), 0, 0, 1, 0, 32'h0010d000);
    look("R9", 1, mkva(16, 2, 0), 0, 0, 1, 0, 32'h00116000);

    // R11 lookup alongside fill sees old state
    req = "R11";
    drive(1, mkva(30, 0, 0), 0, 0, 1, {34'd30, 2'd0}, 20'h04444, 0, 1, 1, 0);
    @(negedge clk_i);
    chk(lk_hit_o === 1'b0, "R11", "hit same cycle", 64'(lk_hit_o), 64'h0);
    look("R11", 1, mkva(30, 0, 0), 0, 0, 1, 0, 32'h04444000);
    req = "R11";
    drive(1, mkva(13, 2, 0), 0, 0, 1, {34'd13, 2'd2}, 20'h05555, 0, 1, 1, 0);
    @(negedge clk_i);
    chk(lk_paddr_o === 32'h0010d000, "R11", "old paddr", 64'(lk_paddr_o), 64'h0010d000);
    look("R11", 1, mkva(13, 2, 0), 0, 0, 1, 0, 32'h05555000);

    // R10 flush
    req = "R10";
    drive(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 1);
    look("R10", 1, mkva(1, 1, 0), 0, 0, 0, 0, 32'h0);
    look("R10", 1, mkva(14, 2, 0), 0, 0, 0, 0, 32'h0);
    req = "R10";
    drive(0, '0, 0, 0, 1, {34'd40, 2'd3}, 20'h00040, 0, 1, 1, 1);
    look("R10", 1, mkva(40, 3, 0), 0, 0, 0, 0, 32'h0);

    // mixed traffic against the model
    req = "R8";
    for (int i = 0; i < 600; i++) begin
      drive($urandom_range(0, 1), mkva(34'($urandom_range(0, 5)), 2'($urandom_range(0, 3)),
            12'($urandom)), $urandom_range(0, 1), $urandom_range(0, 1),
            ($urandom_range(0, 2) == 0), {34'($urandom_range(0, 5)), 2'($urandom_range(0, 3))},
            20'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            ($urandom_range(0, 60) == 0));
    end
    drive(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0);
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule